// File: doc/BRIEF.md
# Address-Change Terminated Write Capture

This block takes processor writes into a small on-cartridge RAM on a cartridge port that carries neither a read/write line nor the processor's phase-2 clock. A fast local clock samples the 13-bit address bus and the 8-bit data bus through two-flop synchronisers. While the accepted address sits inside the write window, the block keeps a two-deep history of data samples. When the address moves on, the block takes the byte from that history, counting back from the change, and writes it into the internal RAM at the offset of the old address.

An address counts as new only after it has matched on two consecutive synchronised samples. A one-sample glitch from bus skew therefore neither ends a write nor starts one. A processor instruction that holds one address for two bus cycles gives a single commit, at the moment that address is finally left. A separate read window over the same RAM drives read data onto the bus, with an output enable that follows the synchronised address.

The map, with A12 as the cartridge select bit: write window `0x1000`–`0x107F`, read window `0x1080`–`0x10FF`. Bits 6:0 of the address are the RAM offset. Any address with A12 low, or with any of bits 11:8 set, belongs to neither window.

Top module: `awc_write_capture`

## Requirements
- R1: While reset is held and straight after its release, `bus_data_oe` and `commit_valid` are 0.
- R2: When the accepted address leaves a write-window address after two or more samples, exactly one one-clock `commit_valid` pulse occurs. `commit_offset` is bits 6:0 of the old address, and `commit_data` is the second-to-last data sample taken while that address was held.
- R3: If exactly one data sample was taken before the change, the commit carries that last sample. This happens when the address is held for three local clocks.
- R4: If no data sample was taken before the change, no commit occurs. This happens when the address is held for two local clocks.
- R5: An address held over two back-to-back bus cycles gives one commit only, at its final change, with data from the end of the second cycle.
- R6: A different address present for only one local-clock sample is not accepted as a change. It causes no commit and does not end the write in progress.
- R7: Addresses with A12 low, or outside both windows, give no commit and leave the RAM unchanged.
- R8: `bus_data_oe` equals the read-window membership of `bus_addr` three local clocks earlier. It is 1 only for read-window addresses and drops within one clock of the synchronised address leaving the window.
- R9: A move from one write-window address directly to another commits the first write and starts a fresh history for the second.
- R10: A committed byte is returned on `bus_data_out`, with `bus_data_oe` high, when the read-window address with the same offset is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 13 | Cartridge address bus, asynchronous to `clk` |
| bus_data_in | input | 8 | Cartridge data bus as driven by the processor |
| bus_data_out | output | 8 | Read data for the read window |
| bus_data_oe | output | 1 | Drive enable for `bus_data_out` |
| commit_valid | output | 1 | One-clock pulse when a write is committed to the RAM |
| commit_offset | output | 7 | RAM offset of the committed write |
| commit_data | output | 8 | Byte committed |

## Verification
A wrong sample count or a stale history shows up at the commit of the same write, about three clocks after the address changes. It appears as the wrong byte on `commit_data`: the last sample instead of the second-to-last, or the reverse. It can also appear as a commit that should not exist, or a commit that is missing. A broken change filter shows within one bus cycle, as an extra commit on a glitch or on the two-cycle write. A wrong RAM offset or write only surfaces at the next read-window access to that offset, a few clocks after the address is presented.

// File: rtl/awc_pkg.sv
package awc_pkg;
  localparam int CART_AW    = 13;
  localparam int BYTE_W     = 8;
  localparam int WIN_OFS_W  = 7;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_WRITE = 2'd1,
    WIN_READ  = 2'd2
  } awc_win_e;
endpackage

// File: rtl/awc_sync.sv
module awc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/awc_win_decode.sv
module awc_win_decode
  import awc_pkg::*;
#(
  parameter int AW    = CART_AW,
  parameter int OFS_W = WIN_OFS_W
) (
  input  logic [AW-1:0] addr,
  output awc_win_e      win
);
  localparam int SEL_BIT = AW - 1;
  localparam int ZERO_HI = AW - 2;
  localparam int ZERO_LO = OFS_W + 1;

  always_comb begin
    win = WIN_NONE;
    if (addr[SEL_BIT] && (addr[ZERO_HI:ZERO_LO] == '0)) begin
      win = addr[OFS_W] ? WIN_READ : WIN_WRITE;
    end
  end
endmodule

// File: rtl/awc_addr_track.sv
module awc_addr_track #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_now,
  output logic [AW-1:0] acc_q,
  output logic          chg,
  output logic          match
);
  logic [AW-1:0] prev_q;
  logic [AW-1:0] acc_d;

  always_comb begin
    chg   = (a_now == prev_q) && (a_now != acc_q);
    match = (a_now == acc_q);
    acc_d = chg ? a_now : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      acc_q  <= '0;
    end else begin
      prev_q <= a_now;
      acc_q  <= acc_d;
    end
  end
endmodule

// File: rtl/awc_history.sv
module awc_history #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] sel,
  output logic [1:0]    cnt,
  output logic          any
);
  localparam logic [1:0] SAT = 2'd2;

  logic [DW-1:0] last_q, last_d, prior_q, prior_d;
  logic [1:0]    cnt_q, cnt_d;

  always_comb begin
    last_d  = last_q;
    prior_d = prior_q;
    cnt_d   = cnt_q;
    if (clr) begin
      last_d  = '0;
      prior_d = '0;
      cnt_d   = '0;
    end else if (shift) begin
      prior_d = last_q;
      last_d  = din;
      cnt_d   = (cnt_q == SAT) ? SAT : cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      prior_q <= '0;
      cnt_q   <= '0;
    end else begin
      last_q  <= last_d;
      prior_q <= prior_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sel = (cnt_q == SAT) ? prior_q : last_q;
  assign cnt = cnt_q;
  assign any = (cnt_q != 2'd0);
endmodule

// File: rtl/awc_ram.sv
module awc_ram #(
  parameter int DW    = 8,
  parameter int OFS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFS_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [OFS_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << OFS_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/awc_write_capture.sv
module awc_write_capture
  import awc_pkg::*;
#(
  parameter int AW          = CART_AW,
  parameter int DW          = BYTE_W,
  parameter int OFS_W       = WIN_OFS_W,
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data_in,
  output logic [DW-1:0]    bus_data_out,
  output logic             bus_data_oe,
  output logic             commit_valid,
  output logic [OFS_W-1:0] commit_offset,
  output logic [DW-1:0]    commit_data
);
  logic          rst_n_i;
  logic [AW-1:0] a_sync;
  logic [DW-1:0] d_sync;
  logic [AW-1:0] acc_addr;
  logic          chg, match;
  awc_win_e      win_acc, win_raw;
  logic          in_wr, shift_en, commit_d, rd_en;
  logic [DW-1:0] hist_sel;
  logic [1:0]    hist_cnt;
  logic          hist_any;

  logic             cmt_v_q;
  logic [OFS_W-1:0] cmt_ofs_q;
  logic [DW-1:0]    cmt_dat_q;
  logic             oe_q;

  // reset: asserted asynchronously, released on clk
  awc_sync #(.W(1), .STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_i)
  );

  awc_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_async (
    .clk(clk), .rst_n(rst_n_i), .d(bus_addr), .q(a_sync)
  );

  awc_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_dsync (
    .clk(clk), .rst_n(rst_n_i), .d(bus_data_in), .q(d_sync)
  );

  awc_addr_track #(.AW(AW)) u_track (
    .clk(clk), .rst_n(rst_n_i), .a_now(a_sync),
    .acc_q(acc_addr), .chg(chg), .match(match)
  );

  awc_win_decode #(.AW(AW), .OFS_W(OFS_W)) u_dec_acc (
    .addr(acc_addr), .win(win_acc)
  );

  awc_win_decode #(.AW(AW), .OFS_W(OFS_W)) u_dec_raw (
    .addr(a_sync), .win(win_raw)
  );

  always_comb begin
    in_wr    = (win_acc == WIN_WRITE);
    shift_en = in_wr && match;
    commit_d = chg && in_wr && hist_any;
    rd_en    = (win_raw == WIN_READ);
  end

  awc_history #(.DW(DW)) u_hist (
    .clk(clk), .rst_n(rst_n_i), .clr(chg), .shift(shift_en),
    .din(d_sync), .sel(hist_sel), .cnt(hist_cnt), .any(hist_any)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cmt_v_q   <= 1'b0;
      cmt_ofs_q <= '0;
      cmt_dat_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      cmt_v_q <= commit_d;
      oe_q    <= rd_en;
      if (commit_d) begin
        cmt_ofs_q <= acc_addr[OFS_W-1:0];
        cmt_dat_q <= hist_sel;
      end
    end
  end

  awc_ram #(.DW(DW), .OFS_W(OFS_W)) u_ram (
    .clk(clk), .rst_n(rst_n_i),
    .we(cmt_v_q), .waddr(cmt_ofs_q), .wdata(cmt_dat_q),
    .re(rd_en), .raddr(a_sync[OFS_W-1:0]), .rdata(bus_data_out)
  );

  assign bus_data_oe   = oe_q;
  assign commit_valid  = cmt_v_q;
  assign commit_offset = cmt_ofs_q;
  assign commit_data   = cmt_dat_q;
endmodule

// File: rtl/awc_write_capture_chk.sv
module awc_write_capture_chk #(
  parameter int AW    = 13,
  parameter int OFS_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_data_oe,
  input logic             commit_valid,
  input logic [OFS_W-1:0] commit_offset,
  input logic [AW-1:0]    acc_addr,
  input logic [1:0]       hist_cnt
);
  localparam int LAT = 3;

  logic [1:0] cyc_q;
  logic       ready, pin_rd, acc_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= 2'd0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  assign ready  = (cyc_q == 2'd3);
  assign pin_rd = bus_addr[AW-1] && (bus_addr[AW-2:OFS_W+1] == '0) && bus_addr[OFS_W];
  assign acc_wr = acc_addr[AW-1] && (acc_addr[AW-2:OFS_W+1] == '0) && !acc_addr[OFS_W];

  // R8: drive enable follows the pin address through the sampling pipeline
  p_oe_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (bus_data_oe == $past(pin_rd, LAT)));

  // R2: a commit lasts one clock only
  p_commit_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid);

  // R2: committed offset is that of the address just left
  p_commit_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> (commit_offset == $past(acc_addr[OFS_W-1:0])));

  // R7: commits only come from an accepted write-window address
  p_commit_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(acc_wr));

  // R4: no commit without at least one sample
  p_commit_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> ($past(hist_cnt) != 2'd0));

  // R3: the sample counter saturates at two
  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hist_cnt != 2'd3);
endmodule

bind awc_write_capture awc_write_capture_chk #(.AW(AW), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .bus_addr(bus_addr), .bus_data_oe(bus_data_oe),
  .commit_valid(commit_valid), .commit_offset(commit_offset),
  .acc_addr(acc_addr), .hist_cnt(hist_cnt)
);

// File: tb/awc_write_capture_test.sv
module awc_write_capture_test;
  localparam logic [12:0] WR_BASE = 13'h1000;
  localparam logic [12:0] RD_BASE = 13'h1080;
  localparam logic [12:0] FETCH   = 13'h1F00;

  // vector: {offset[6:0], hold clocks[7:0], byte[7:0]}
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {7'h00, 8'd6,   8'hA5},
    {7'h7F, 8'd10,  8'h3C},
    {7'h21, 8'd59,  8'h81},
    {7'h40, 8'd4,   8'h00},
    {7'h15, 8'd30,  8'hFF},
    {7'h33, 8'd105, 8'h6E}
  };

  logic        clk;
  logic        rst_n;
  logic [12:0] bus_addr;
  logic [7:0]  bus_data_in;
  logic [7:0]  bus_data_out;
  logic        bus_data_oe;
  logic        commit_valid;
  logic [6:0]  commit_offset;
  logic [7:0]  commit_data;

  int n_checks = 0;
  int n_fail   = 0;
  int n_cmt    = 0;
  logic [6:0] last_ofs, prev_ofs;
  logic [7:0] last_dat, prev_dat;

  awc_write_capture uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data_in(bus_data_in),
    .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .commit_valid(commit_valid), .commit_offset(commit_offset),
    .commit_data(commit_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // commit monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (commit_valid) begin
      n_cmt    = n_cmt + 1;
      prev_ofs = last_ofs;
      prev_dat = last_dat;
      last_ofs = commit_offset;
      last_dat = commit_data;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [12:0] a, input logic [7:0] d, input int n);
    bus_addr    = a;
    bus_data_in = d;
    repeat (n) @(negedge clk);
  endtask

  // H clocks on one address: filler, then the valid byte, then a corrupt last sample
  task automatic write_cycle(input logic [6:0] ofs, input int h, input logic [7:0] v);
    drive(WR_BASE | 13'(ofs), 8'h5A, h - 2);
    drive(WR_BASE | 13'(ofs), v, 1);
    drive(WR_BASE | 13'(ofs), ~v, 1);
  endtask

  task automatic read_check(input string req, input logic [6:0] ofs, input logic [7:0] exp);
    drive(RD_BASE | 13'(ofs), 8'h00, 5);
    check(req, int'(bus_data_oe), 1);
    check(req, int'(bus_data_out), int'(exp));
    drive(FETCH, 8'hFF, 4);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int base;
    rst_n       = 1'b0;
    bus_addr    = '0;
    bus_data_in = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 oe in reset", int'(bus_data_oe), 0);
    check("R1 commit in reset", int'(commit_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 oe after reset", int'(bus_data_oe), 0);
    check("R1 no commits", n_cmt, 0);

    // R2 / R10: table walk
    for (int i = 0; i < NV; i++) begin
      logic [6:0] o;
      logic [7:0] h, v;
      {o, h, v} = VEC[i];
      base = n_cmt;
      write_cycle(o, int'(h), v);
      drive(FETCH, 8'hFF, 8);
      check("R2 one commit", n_cmt - base, 1);
      check("R2 offset", int'(last_ofs), int'(o));
      check("R2 second-to-last byte", int'(last_dat), int'(v));
      read_check("R10 readback", o, v);
    end

    // R3: three clocks held -> one sample, the last one
    base = n_cmt;
    drive(WR_BASE | 13'h05, 8'h12, 2);
    drive(WR_BASE | 13'h05, 8'h99, 1);
    drive(FETCH, 8'hFF, 8);
    check("R3 one commit", n_cmt - base, 1);
    check("R3 last sample used", int'(last_dat), 8'h99);

    // R4: two clocks held -> no sample, no commit
    base = n_cmt;
    drive(WR_BASE | 13'h06, 8'h44, 2);
    drive(FETCH, 8'hFF, 8);
    check("R4 no commit", n_cmt - base, 0);

    // R5: same address for two bus cycles
    base = n_cmt;
    drive(WR_BASE | 13'h08, 8'h11, 20);
    drive(WR_BASE | 13'h08, 8'h22, 17);
    drive(WR_BASE | 13'h08, 8'hEE, 1);
    drive(FETCH, 8'hFF, 8);
    check("R5 single commit", n_cmt - base, 1);
    check("R5 second cycle data", int'(last_dat), 8'h22);

    // R6: one-sample glitch inside a write
    base = n_cmt;
    drive(WR_BASE | 13'h09, 8'h5A, 6);
    drive(FETCH, 8'h5A, 1);
    drive(WR_BASE | 13'h09, 8'h5A, 4);
    drive(WR_BASE | 13'h09, 8'h47, 1);
    drive(WR_BASE | 13'h09, 8'hB8, 1);
    drive(FETCH, 8'hFF, 8);
    check("R6 glitch ignored", n_cmt - base, 1);
    check("R6 data", int'(last_dat), 8'h47);

    // R7: A12 low and out-of-window addresses
    base = n_cmt;
    drive(13'h0005, 8'h77, 10);
    drive(13'h1105, 8'h77, 10);
    drive(FETCH, 8'hFF, 8);
    check("R7 no commit", n_cmt - base, 0);
    read_check("R7 ram unchanged", 7'h05, 8'h99);

    // R9: write window to write window
    base = n_cmt;
    write_cycle(7'h10, 6, 8'hC1);
    write_cycle(7'h11, 6, 8'hD2);
    drive(FETCH, 8'hFF, 8);
    check("R9 two commits", n_cmt - base, 2);
    check("R9 first offset", int'(prev_ofs), 8'h10);
    check("R9 first data", int'(prev_dat), 8'hC1);
    check("R9 second data", int'(last_dat), 8'hD2);

    // R8: enable only in the read window, dropped after leaving
    drive(WR_BASE | 13'h10, 8'h00, 6);
    check("R8 oe off in write window", int'(bus_data_oe), 0);
    drive(RD_BASE | 13'h10, 8'h00, 6);
    check("R8 oe on in read window", int'(bus_data_oe), 1);
    drive(FETCH, 8'hFF, 4);
    check("R8 oe dropped", int'(bus_data_oe), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule